// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Output Mode

This block gathers up to sixteen single-cycle event pulses from a bus terminal into a sticky status register and drives one active-low interrupt request pin toward the host. A mask register names which sources may raise the pin. A configuration write selects how the pin behaves and how masked sources are recorded. The pin can emit a one-cycle pulse per enabled event, hold a level until software clears it, or hold a level that drops once the host reads status.

Two recording rules exist. In the standard rule, a source reaches the status register only when its mask bit is set. In the enhanced rule, every source is recorded regardless of its mask. The host can then poll masked conditions, but only enabled ones drive the pin. Status is visible on a read-data output at all times. A read strobe and a software clear command act on it.

Top module: `irq_gather`

## Requirements
- R1: After reset the pin is high, all status bits read 0, the mask is all 0, the pin mode is pulse (code 0) and the recording rule is standard.
- R2: In the standard rule, an event on bit i sets status bit i in the following cycle only if mask bit i is 1. Otherwise that status bit is unchanged.
- R3: In the enhanced rule (configuration enable bit = 1), an event on bit i sets status bit i in the following cycle whatever mask bit i holds.
- R4: In either level mode the pin is low exactly while some status bit and its mask bit are both 1. A status bit whose mask bit is 0 never pulls the pin low.
- R5: In pulse mode the pin is low for exactly the one cycle after each cycle that carries an event on a mask-enabled bit, and high otherwise.
- R6: In level-with-software-clear mode (code 1), a status read strobe leaves the status bits and the pin unchanged.
- R7: In level-with-auto-clear mode (code 2), a status read strobe clears every status bit in the following cycle. An event arriving in the same cycle as the read is recorded, not lost.
- R8: The software clear input clears every status bit in the following cycle in any mode, so a level pin goes high unless an event in that same cycle sets a bit again.
- R9: Pin mode code (2 bits) and the recording rule bit are loaded when the configuration write strobe is high. The mask is loaded when the mask write strobe is high. Both take effect from the next cycle. Mode code 3 behaves as code 1.
- R10: Status bits are sticky. Without a clear, a set bit stays set, and later events OR into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses, one bit per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pin_mode_i | input | 2 | Pin mode code: 0 pulse, 1 level software clear, 2 level auto clear, 3 as 1 |
| cfg_enh_i | input | 1 | Recording rule: 0 standard, 1 enhanced |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | NUM_SRC | Mask value, 1 enables a source |
| stat_rd_i | input | 1 | Status read strobe |
| sw_clr_i | input | 1 | Software clear command |
| stat_o | output | NUM_SRC | Current status register contents |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Two functions can fall in the same cycle. One is a status clear, either from a read in auto-clear mode or from the software clear command. The other is a fresh event on the same or another source. The bench drives a read or clear together with a nonzero event vector, in directed cases and in a long pseudo-random stretch. A cycle-accurate behavioural model predicts the status word and the pin, and the bench compares them on every cycle. The expected result is that the new event's bits survive the clear and, if enabled, hold the level pin low.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        PIN_PULSE    = 2'd0,
        PIN_LVL_SW   = 2'd1,
        PIN_LVL_AUTO = 2'd2,
        PIN_LVL_ALT  = 2'd3
    } pin_mode_e;

    typedef struct packed {
        pin_mode_e mode;
        logic      enh;
    } cfg_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_pin_mode_i,
    input  logic               cfg_enh_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output cfg_t               cfg_o,
    output logic [NUM_SRC-1:0] mask_o
);

    typedef struct packed {
        cfg_t               cfg;
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we_i) begin
            regs_d.cfg.mode = pin_mode_e'(cfg_pin_mode_i);
            regs_d.cfg.enh  = cfg_enh_i;
        end
        if (mask_we_i) begin
            regs_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cfg.mode <= PIN_PULSE;
            regs_q.cfg.enh  <= 1'b0;
            regs_q.mask     <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o  = regs_q.cfg;
    assign mask_o = regs_q.mask;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  cfg_t               cfg_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               stat_rd_i,
    input  logic               sw_clr_i,
    output logic [NUM_SRC-1:0] stat_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_SRC-1:0] gate;
    logic               wipe;

    always_comb begin
        gate   = cfg_i.enh ? {NUM_SRC{1'b1}} : mask_i;
        wipe   = sw_clr_i || (stat_rd_i && (cfg_i.mode == PIN_LVL_AUTO));
        bank_d = bank_q;
        if (wipe) begin
            bank_d.stat = '0;
        end
        bank_d.stat = bank_d.stat | (evt_i & gate);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.stat <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  cfg_t               cfg_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] stat_i,
    output logic               irq_n_o
);

    typedef struct packed {
        logic pulse;
    } pin_t;

    pin_t pin_d, pin_q;
    logic level_hit;

    always_comb begin
        pin_d.pulse = |(evt_i & mask_i);
        level_hit   = |(stat_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q.pulse <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign irq_n_o = (cfg_i.mode == PIN_PULSE) ? ~pin_q.pulse : ~level_hit;

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_pin_mode_i,
    input  logic               cfg_enh_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               stat_rd_i,
    input  logic               sw_clr_i,
    output logic [NUM_SRC-1:0] stat_o,
    output logic               irq_n_o
);

    cfg_t               cfg_q;
    pin_mode_e          pin_mode_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_q;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC)) i_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we_i       (cfg_we_i),
        .cfg_pin_mode_i (cfg_pin_mode_i),
        .cfg_enh_i      (cfg_enh_i),
        .mask_we_i      (mask_we_i),
        .mask_i         (mask_i),
        .cfg_o          (cfg_q),
        .mask_o         (mask_q)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .cfg_i     (cfg_q),
        .mask_i    (mask_q),
        .stat_rd_i (stat_rd_i),
        .sw_clr_i  (sw_clr_i),
        .stat_o    (stat_q)
    );

    irq_pin_drive #(.NUM_SRC(NUM_SRC)) i_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .cfg_i   (cfg_q),
        .mask_i  (mask_q),
        .stat_i  (stat_q),
        .irq_n_o (irq_n_o)
    );

    assign pin_mode_q = cfg_q.mode;
    assign stat_o     = stat_q;

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               cfg_we_i,
    input logic               mask_we_i,
    input logic               stat_rd_i,
    input logic               sw_clr_i,
    input logic [NUM_SRC-1:0] stat_o,
    input logic               irq_n_o,
    input pin_mode_e          mode_q,
    input logic [NUM_SRC-1:0] mask_q
);

    // R8: a clear with no concurrent event empties status
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && evt_i == '0) |=> (stat_o == '0));

    // R7: auto-clear read with no concurrent event empties status
    a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIN_LVL_AUTO && stat_rd_i && !sw_clr_i && evt_i == '0) |=> (stat_o == '0));

    // R10: without a clear, no set bit drops
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clr_i && !(mode_q == PIN_LVL_AUTO && stat_rd_i))
        |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R4: level pin high when no enabled status bit is set
    a_r4_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PIN_PULSE && (stat_o & mask_q) == '0) |-> irq_n_o);

    // R4: level pin low when an enabled status bit is set
    a_r4_level_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PIN_PULSE && (stat_o & mask_q) != '0) |-> !irq_n_o);

    // R5: no enabled event means no pulse next cycle
    a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIN_PULSE && (evt_i & mask_q) == '0 && !cfg_we_i && !mask_we_i) |=> irq_n_o);

endmodule

bind irq_gather irq_gather_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .cfg_we_i  (cfg_we_i),
    .mask_we_i (mask_we_i),
    .stat_rd_i (stat_rd_i),
    .sw_clr_i  (sw_clr_i),
    .stat_o    (stat_o),
    .irq_n_o   (irq_n_o),
    .mode_q    (pin_mode_q),
    .mask_q    (mask_q)
);

// File: tb/test_irq_gather.sv
module test_irq_gather;

    localparam int PERIOD = 10;
    localparam int N      = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         cfg_enh = 1'b0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_in = '0;
    logic         rd = 1'b0;
    logic         clr = 1'b0;
    logic [N-1:0] stat;
    logic         irq_n;

    int checks = 0;
    int errors = 0;
    string tag = "R1 reset";

    // reference model state
    int           m_mode = 0;
    bit           m_enh = 1'b0;
    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_stat = '0;
    bit           m_pulse = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    irq_gather #(.NUM_SRC(N)) i_irq_gather (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_i          (evt),
        .cfg_we_i       (cfg_we),
        .cfg_pin_mode_i (cfg_mode),
        .cfg_enh_i      (cfg_enh),
        .mask_we_i      (mask_we),
        .mask_i         (mask_in),
        .stat_rd_i      (rd),
        .sw_clr_i       (clr),
        .stat_o         (stat),
        .irq_n_o        (irq_n)
    );

    task automatic compare();
        logic exp_n;
        exp_n = (m_mode == 0) ? !m_pulse : !(|(m_stat & m_mask));
        checks++;
        if (stat !== m_stat) begin
            errors++;
            $display("FAIL %s: status actual %h expected %h", tag, stat, m_stat);
        end
        checks++;
        if (irq_n !== exp_n) begin
            errors++;
            $display("FAIL %s: pin actual %b expected %b", tag, irq_n, exp_n);
        end
    endtask

    task automatic model_update();
        logic [N-1:0] gate;
        bit wipe;
        gate    = m_enh ? '1 : m_mask;
        wipe    = clr || (m_mode == 2 && rd);
        m_pulse = |(evt & m_mask);
        m_stat  = (wipe ? '0 : m_stat) | (evt & gate);
        if (cfg_we) begin
            m_mode = (cfg_mode == 2'd3) ? 1 : int'(cfg_mode);
            m_enh  = cfg_enh;
        end
        if (mask_we) m_mask = mask_in;
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic [N-1:0] e, input bit r = 0, input bit c = 0);
        evt = e; rd = r; clr = c;
        @(posedge clk);
        model_update();
        @(negedge clk);
        evt = '0; rd = 1'b0; clr = 1'b0; cfg_we = 1'b0; mask_we = 1'b0;
        compare();
    endtask

    task automatic set_cfg(input logic [1:0] md, input bit en);
        cfg_we = 1'b1; cfg_mode = md; cfg_enh = en;
        step('0);
    endtask

    task automatic set_mask(input logic [N-1:0] mk);
        mask_we = 1'b1; mask_in = mk;
        step('0);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        compare();                       // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        tag = "R1 mask zero after reset";
        step(16'hFFFF);                  // standard rule, mask 0: nothing recorded
        step('0);

        tag = "R9 config write";
        set_cfg(2'd1, 1'b0);
        set_mask(16'h00F0);
        tag = "R2 standard gating";
        step(16'h0F10);                  // only bit 4 enabled
        tag = "R4 level pin";
        step('0);
        tag = "R10 sticky accumulate";
        step(16'h0020);
        step(16'h0001);
        tag = "R6 read no clear";
        step('0, 1'b1);
        step('0);
        tag = "R8 clear with event";
        step(16'h0040, 1'b0, 1'b1);
        tag = "R8 clear plain";
        step('0, 1'b0, 1'b1);

        tag = "R3 enhanced";
        set_cfg(2'd1, 1'b1);
        set_mask(16'h0001);
        step(16'h8000);                  // recorded, pin stays high (R4)
        tag = "R4 masked bit no pin";
        step('0);
        tag = "R3 enabled bit pin";
        step(16'h0001);
        step('0, 1'b0, 1'b1);

        tag = "R7 auto clear";
        set_cfg(2'd2, 1'b0);
        set_mask(16'h0F0F);
        step(16'h0303);
        step('0, 1'b1);
        tag = "R7 read with event";
        step(16'h0005);
        step(16'h0100, 1'b1);
        step('0);
        step('0, 1'b1);

        tag = "R5 pulse";
        set_cfg(2'd0, 1'b0);
        step(16'h0001);
        step(16'h0002);
        step('0);
        step(16'hF0F0);                  // masked sources: no pulse
        step('0);
        step(16'h0800);
        step('0);

        tag = "R9 mode code 3";
        set_cfg(2'd3, 1'b0);
        step(16'h0004);
        step('0, 1'b1);                  // behaves as software clear mode
        step('0, 1'b0, 1'b1);

        tag = "R10 random mix";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) begin
                cfg_we = 1'b1; cfg_mode = lfsr[5:4]; cfg_enh = lfsr[6];
            end
            if (lfsr[9:7] == 3'd1) begin
                mask_we = 1'b1; mask_in = {lfsr[7:0], lfsr[15:8]};
            end
            step(lfsr & {lfsr[3:0], lfsr[15:4]}, lfsr[10] & lfsr[11], lfsr[12] & lfsr[13] & lfsr[14]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule